// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block drives and samples a bank of general-purpose pins. Each pin has its own 32-bit control word on a simple word-addressed register bus. Through that word software picks the direction, sets the driven value, chooses a pull resistor and its direction, and reads the synchronised pin level back. A read-only summary word collects the pending interrupt flags of all pins.

Every pin has an interrupt detector. Three bits set its trigger: a high-sensitivity bit, a low-sensitivity bit and a mode bit. In edge mode the detector catches rising edges, falling edges or both. In level mode it catches an active-high or an active-low level. A detected event sets a sticky pending flag in the pin's control word. Software acknowledges the flag by writing a one to it, which means it can write back the word it read. A pin with a pending flag and its interrupt enable set drives the single registered bank interrupt line.

Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the sample one cycle older.

Top module: `gpb_bank`

## Requirements
- R1: Control word bit layout: bit0 interrupt enable, bit1 pending flag, bit2 high-sensitivity, bit3 low-sensitivity, bit4 mode (1 = edge, 0 = level), bit5 output enable, bit6 drive value, bit7 sampled input (read-only), bit8 pull enable, bit9 pull direction (1 = up). Bits 0, 2, 3, 4, 5, 6, 8 and 9 read back what was last written. The word for pin n is at word address n.
- R2: `pin_oe[n]` follows bit5 and `pin_out[n]` follows bit6 of pin n's word. When bit5 is clear the pin is an input.
- R3: Bit7 of pin n's word always reflects `pin_in[n]` after a two-flop synchroniser. A change at the pin is visible within three clock cycles.
- R4: `pad_pu[n]` equals bit8 AND bit9, and `pad_pd[n]` equals bit8 AND NOT bit9. With bit8 clear, neither pull is active.
- R5: In edge mode, high alone sets the pending flag on a rising edge, low alone sets it on a falling edge, and both set it on either edge.
- R6: In level mode, high with low clear sets the pending flag while the synchronised level is 1, and low with high clear sets it while the level is 0. Both set, or both clear, never sets the flag.
- R7: The pending flag is sticky. Writing a word with bit1 = 1 clears it. A write with bit1 = 0 leaves it unchanged.
- R8: A detection in the same cycle as a clear wins, so in level mode the flag stays set while the level remains active. In edge mode a cleared flag sets again only on a new qualifying edge.
- R9: The read-only summary word at word address 32 has bit n equal to pin n's pending flag.
- R10: `bank_irq` is the OR over all pins of (pending AND enable), registered one cycle. A pending pin with its enable clear does not raise it.
- R11: After reset all control fields, pending flags, `pin_oe`, the pulls and `bank_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Word address (0..31 pin words, 32 summary word) |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Raw pin levels |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin driven value |
| pad_pu | output | 32 | Per-pin pull-up request |
| pad_pd | output | 32 | Per-pin pull-down request |
| bank_irq | output | 1 | Bank interrupt line |

## Verification
A pending flag that is set wrongly, or one that fails to clear, shows on the summary word in the cycle after the fault. It also reaches `bank_irq` one cycle later if that pin's enable is set. A detector that decodes the three trigger bits wrongly shows up about three cycles after the pin change that should, or should not, set the flag. The synchroniser and edge register set that delay. A wrong write decode shows at once as a mismatch on readback or on the pad outputs.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int F_IEN  = 0;
  localparam int F_STS  = 1;
  localparam int F_HI   = 2;
  localparam int F_LO   = 3;
  localparam int F_EDGE = 4;
  localparam int F_OE   = 5;
  localparam int F_DOUT = 6;
  localparam int F_DIN  = 7;
  localparam int F_PEN  = 8;
  localparam int F_PUP  = 9;

  typedef struct packed {
    logic ien;
    logic hi;
    logic lo;
    logic edge_md;
    logic oe;
    logic dout;
    logic pen;
    logic pup;
  } pin_cfg_t;

  // Trigger decision from the config and two successive synchronised samples.
  function automatic logic trig_hit(input pin_cfg_t c, input logic cur, input logic prv);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (c.edge_md)
      trig_hit = (c.hi & rise) | (c.lo & fall);
    else
      trig_hit = (c.hi & ~c.lo & cur) | (c.lo & ~c.hi & ~cur);
  endfunction

  function automatic pin_cfg_t cfg_from_word(input logic [31:0] w);
    pin_cfg_t c;
    c.ien     = w[F_IEN];
    c.hi      = w[F_HI];
    c.lo      = w[F_LO];
    c.edge_md = w[F_EDGE];
    c.oe      = w[F_OE];
    c.dout    = w[F_DOUT];
    c.pen     = w[F_PEN];
    c.pup     = w[F_PUP];
    return c;
  endfunction

  function automatic logic [31:0] word_from_cfg(input pin_cfg_t c, input logic sts, input logic din);
    logic [31:0] w;
    w = '0;
    w[F_IEN]  = c.ien;
    w[F_STS]  = sts;
    w[F_HI]   = c.hi;
    w[F_LO]   = c.lo;
    w[F_EDGE] = c.edge_md;
    w[F_OE]   = c.oe;
    w[F_DOUT] = c.dout;
    w[F_DIN]  = din;
    w[F_PEN]  = c.pen;
    w[F_PUP]  = c.pup;
    return w;
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpb_pin.sv
module gpb_pin
  import gpb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          smp_cur,
  input  logic          smp_prv,
  output logic [DW-1:0] ctrl_word,
  output logic          hit,
  output logic          clr,
  output logic          sts,
  output logic          ien,
  output logic          oe,
  output logic          dout,
  output logic          pu,
  output logic          pd
);
  pin_cfg_t cfg;

  assign hit = trig_hit(cfg, smp_cur, smp_prv);
  assign clr = wr & wdata[F_STS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      sts <= 1'b0;
    end else begin
      if (wr) cfg <= cfg_from_word(wdata);
      sts <= hit | (sts & ~clr);
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[31:0] = word_from_cfg(cfg, sts, smp_cur);
  end

  assign ien  = cfg.ien;
  assign oe   = cfg.oe;
  assign dout = cfg.dout;
  assign pu   = cfg.pen & cfg.pup;
  assign pd   = cfg.pen & ~cfg.pup;
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank #(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = $clog2(NPINS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wen,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd,
  output logic             bank_irq
);
  localparam logic [AW-1:0] SUM_ADDR = AW'(NPINS);

  logic [NPINS-1:0] smp_cur, smp_prv;
  logic [NPINS-1:0] sts_vec, en_vec, hit_vec, clr_vec;
  logic [DW-1:0]    ctrl_words [NPINS];

  gpb_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_prv <= '0;
    else        smp_prv <= smp_cur;
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic sel_wr;
    assign sel_wr = bus_wen && (bus_addr == AW'(n));
    gpb_pin #(.DW(DW)) u_pin (
      .clk(clk), .rst_n(rst_n),
      .wr(sel_wr), .wdata(bus_wdata),
      .smp_cur(smp_cur[n]), .smp_prv(smp_prv[n]),
      .ctrl_word(ctrl_words[n]),
      .hit(hit_vec[n]), .clr(clr_vec[n]),
      .sts(sts_vec[n]), .ien(en_vec[n]),
      .oe(pin_oe[n]), .dout(pin_out[n]),
      .pu(pad_pu[n]), .pd(pad_pd[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == SUM_ADDR)
      bus_rdata[NPINS-1:0] = sts_vec;
    else if (bus_addr < SUM_ADDR)
      bus_rdata = ctrl_words[bus_addr[AW-2:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_irq <= 1'b0;
    else        bank_irq <= |(sts_vec & en_vec);
  end
endmodule

// File: rtl/gpb_bank_chk.sv
module gpb_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] sts_vec,
  input logic [NPINS-1:0] en_vec,
  input logic [NPINS-1:0] hit_vec,
  input logic [NPINS-1:0] clr_vec,
  input logic             bank_irq
);
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_vec & en_vec)) |=> bank_irq);
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_vec & en_vec)) |=> !bank_irq);

  for (genvar n = 0; n < NPINS; n++) begin : g_chk
    // R8
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[n] |=> sts_vec[n]);
    // R7
    sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[n] && !hit_vec[n]) |=> !sts_vec[n]);
    // R7
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_vec[n] && !clr_vec[n]) |=> sts_vec[n]);
    // R5
    sts_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_vec[n]) |-> $past(hit_vec[n]));
  end
endmodule

bind gpb_bank gpb_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sts_vec(sts_vec), .en_vec(en_vec),
  .hit_vec(hit_vec), .clr_vec(clr_vec), .bank_irq(bank_irq)
);

// File: tb/gpb_bank_bench.sv
module gpb_bank_bench;
  localparam int NP = 32;
  localparam logic [31:0] B_IEN = 32'h1, B_STS = 32'h2, B_HI = 32'h4, B_LO = 32'h8,
                          B_EDGE = 32'h10, B_OE = 32'h20, B_DOUT = 32'h40, B_DIN = 32'h80,
                          B_PEN = 32'h100, B_PUP = 32'h200;

  logic clk = 0, rst_n = 0;
  logic [5:0] bus_addr = '0;
  logic bus_wen = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_oe, pin_out, pad_pu, pad_pd;
  logic bank_irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpb_bank u_gpb_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .bank_irq(bank_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(a); bus_wdata = d; bus_wen = 1;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(a);
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sts_of(input int p, output logic s);
    logic [31:0] d;
    rd(p, d);
    s = d[1];
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);  chk("R11 ctrl0", d, 0);
    rd(32, d); chk("R11 summary", d, 0);
    chk("R11 oe", pin_oe, 0);
    chk("R11 pulls", pad_pu | pad_pd, 0);
    chk("R11 irq", bank_irq, 0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(20, B_OE | B_DOUT);
    chk("R2 oe", pin_oe[20], 1);
    chk("R2 out", pin_out[20], 1);
    rd(20, d); chk("R1 readback", d, B_OE | B_DOUT);
    wr(20, B_DOUT);
    chk("R2 input", pin_oe[20], 0);
    wr(20, 0);
    pin_in[21] = 1; settle(3);
    rd(21, d); chk("R3 din high", d & B_DIN, B_DIN);
    pin_in[21] = 0; settle(3);
    rd(21, d); chk("R3 din low", d & B_DIN, 0);
    wr(22, B_PEN | B_PUP);
    chk("R4 up", {30'b0, pad_pu[22], pad_pd[22]}, 2);
    wr(22, B_PUP);
    chk("R4 off", {30'b0, pad_pu[22], pad_pd[22]}, 0);
    wr(22, B_PEN);
    chk("R4 down", {30'b0, pad_pu[22], pad_pd[22]}, 1);
    wr(22, 0);
  endtask

  task automatic t_rise();
    logic s; logic [31:0] d;
    wr(3, B_IEN | B_HI | B_EDGE); settle(4);
    sts_of(3, s); chk("R5 rise idle", s, 0);
    pin_in[3] = 1; settle(5);
    sts_of(3, s); chk("R5 rise set", s, 1);
    rd(32, d); chk("R9 summary bit3", d, 32'h8);
    chk("R10 irq up", bank_irq, 1);
    wr(3, B_IEN | B_HI | B_EDGE | B_STS); settle(3);
    sts_of(3, s); chk("R8 edge no retrigger", s, 0);
    chk("R10 irq down", bank_irq, 0);
    pin_in[3] = 0; settle(4);
    sts_of(3, s); chk("R5 rise ignores fall", s, 0);
    wr(3, B_STS);
  endtask

  task automatic t_fall_both();
    logic s;
    pin_in[5] = 1; settle(4);
    wr(5, B_LO | B_EDGE); settle(3);
    sts_of(5, s); chk("R5 fall idle", s, 0);
    pin_in[5] = 0; settle(5);
    sts_of(5, s); chk("R5 fall set", s, 1);
    wr(5, B_STS);
    wr(7, B_HI | B_LO | B_EDGE);
    pin_in[7] = 1; settle(5);
    sts_of(7, s); chk("R5 both rise", s, 1);
    wr(7, B_HI | B_LO | B_EDGE | B_STS); settle(2);
    sts_of(7, s); chk("R7 cleared", s, 0);
    pin_in[7] = 0; settle(5);
    sts_of(7, s); chk("R5 both fall", s, 1);
    wr(7, B_STS);
  endtask

  task automatic t_level();
    logic s;
    wr(9, B_IEN | B_HI); settle(3);
    sts_of(9, s); chk("R6 hi idle", s, 0);
    pin_in[9] = 1; settle(5);
    sts_of(9, s); chk("R6 hi set", s, 1);
    wr(9, B_IEN | B_HI | B_STS); settle(1);
    sts_of(9, s); chk("R8 level stays", s, 1);
    chk("R10 irq level", bank_irq, 1);
    pin_in[9] = 0; settle(4);
    wr(9, B_IEN | B_HI | B_STS); settle(2);
    sts_of(9, s); chk("R7 level cleared", s, 0);
    wr(9, B_STS);
    wr(11, B_LO); settle(2);
    sts_of(11, s); chk("R6 lo set", s, 1);
    pin_in[11] = 1; settle(4);
    wr(11, B_LO | B_STS); settle(2);
    sts_of(11, s); chk("R6 lo cleared", s, 0);
    wr(11, B_HI | B_LO); pin_in[11] = 0; settle(4);
    sts_of(11, s); chk("R6 both bits level", s, 0);
    wr(11, 0);
    pin_in[9] = 1; pin_in[11] = 1; settle(3);
  endtask

  task automatic t_w0_enable();
    logic s; logic [31:0] d;
    wr(14, B_HI | B_EDGE);
    pin_in[14] = 1; settle(5);
    rd(32, d); chk("R9 summary bit14", d, 32'h4000);
    chk("R10 masked", bank_irq, 0);
    wr(14, B_HI | B_EDGE | B_IEN); settle(2);
    sts_of(14, s); chk("R7 zero write keeps", s, 1);
    chk("R10 enabled", bank_irq, 1);
    wr(14, B_STS); settle(2);
    rd(32, d); chk("R9 summary empty", d, 0);
    chk("R10 final", bank_irq, 0);
  endtask

  initial begin
    fork
      begin
        settle(3); rst_n = 1; settle(2);
        t_reset(); t_fields(); t_rise(); t_fall_both(); t_level(); t_w0_enable();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule